// File: doc/BRIEF.md
# Multiphase Fault Supervisor with Phase Removal

This block supervises the faults of a bidirectional multiphase converter controller with up to `N_PH` phases. Each phase reports three kinds of fault pulse: negative overcurrent, second-level overcurrent and a switch short. From these pulses the block produces four things:
- a per-phase kill for the synchronous switch, held for the rest of the switching cycle;
- per-phase enables;
- sticky status bits and a fault flag (active low, open-drain style);
- a sequencing state of init, idle, soft-start, run, hiccup or latch-off.

A host programs the block through a small register port. A write lands on the clock edge where `reg_wr_i` is high. A read is combinational from `reg_addr_i`. The port is a plain control port with no back-pressure: every write is accepted in the cycle it is presented.

Before a start, the host can mark phases to leave out. Those phases are then held off for the whole run. The remaining phases keep their own enables, and no phase is moved or re-spaced. If more than half the phases are marked, the block refuses to start and latches off.

Each fault leads to one of three actions: report only, hiccup, or latch-off. By default every fault uses the hiccup or latch-off choice that was latched from the mode input at initialization. A global override bit makes every fault follow its own programmed code instead.

Register map (8-bit data, 3-bit address):
- 0x0 control: bit0 = phase removal enable, bit1 = per-fault override enable.
- 0x1 removal mask: bits [N_PH-1:0].
- 0x2 response codes: [1:0] second-level overcurrent, [3:2] negative overcurrent, [5:4] switch short.
- 0x3 fault status: bit0 second-level overcurrent, bit1 negative overcurrent, bit2 switch short. Write 1 to clear a bit.
- 0x4 faulted phases: one bit per phase. Write 1 to clear a bit.

Response codes: 00 = report only, 01 = hiccup, 10 or 11 = latch-off.

State codes on `state_o`: 0 init, 1 idle, 2 soft-start, 3 run, 4 hiccup, 5 latch-off.

Top module: `phase_fault_supervisor`

## Requirements
- R1: After reset, the block is in the following state:
  - `state_o` = 0 (init);
  - `ph_en_o` and `sync_kill_o` are 0;
  - `fault_n_o` is 1;
  - every register reads 0.
- R2: In init, `chip_en_i` high latches `dflt_latch_i` and moves the block to idle on that edge. Changes of `dflt_latch_i` outside init have no effect. `chip_en_i` low in any state returns the block to init on the next edge with all phases off.
- R3: In idle with `pwm_en_i` high, the next edge enters soft-start. `ph_en_o` is then all ones, or the complement of the removal mask when removal is enabled. After `SS_CYC` further edges the block enters run.
- R4: If removal is enabled and the mask has strictly more than `N_PH/2` bits set, a start enters latch-off instead of soft-start, with all phases off.
- R5: A negative overcurrent pulse on an enabled phase sets that phase's `sync_kill_o` bit on the next edge. The bit stays set until the edge on which `cyc_start_i` is high. A pulse in the same cycle as `cyc_start_i` keeps the bit set for the new switching cycle.
- R6: A fault on an enabled phase sets its status bit (0x3) and its phase bit (0x4). Both bits stay set until 1 is written to them. `fault_n_o` is low while any bit in 0x3 or 0x4 is set.
- R7: With the override bit clear, every fault type goes to latch-off if the latched mode was 1 and to hiccup if it was 0.
- R8: With the override bit set, each fault type follows its own code from 0x2. Code 00 keeps the state unchanged. When several faults arrive together, the most severe action wins.
- R9: Hiccup holds all phases off for `HIC_CYC` edges, then goes to idle. The next edge re-enters soft-start if `pwm_en_i` is high.
- R10: Latch-off holds all phases off until `pwm_en_i` goes low, which leads to idle and a later soft-start, or until `chip_en_i` goes low, which leads to init.
- R11: Fault pulses on disabled phases, or outside soft-start and run, change no status, no kill and no state.
- R12: `pwm_en_i` low in soft-start or run moves the block to idle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_i | input | 1 | Chip enable; low forces init |
| pwm_en_i | input | 1 | PWM enable; high starts, low stops |
| dflt_latch_i | input | 1 | Resolved mode-pin level: 1 = latch-off default, 0 = hiccup |
| cyc_start_i | input | 1 | One-cycle pulse at each switching-cycle start |
| oc2_i | input | N_PH | Second-level overcurrent pulse per phase |
| noc_i | input | N_PH | Negative overcurrent pulse per phase |
| short_i | input | N_PH | Switch-short pulse per phase |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| ph_en_o | output | N_PH | Per-phase enable |
| sync_kill_o | output | N_PH | Per-phase synchronous-switch kill |
| fault_n_o | output | 1 | Fault flag, low while any status bit is set |
| state_o | output | 3 | Sequencing state code |

## Verification
The hardest case to reach is a fault that must be ignored because its phase was removed. It only counts as ignored while the block is actually running on the other phases. The stimulus therefore programs a removal mask and the override codes, and starts the block. While it is still in soft-start, the stimulus pulses a fault on the removed phase and confirms that the state, the status and the flag do not move. It then faults an active phase and confirms the hiccup. Returning from latch-off is reached in the same way, by faulting an active phase with a latch-off code and then releasing the PWM enable.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_IDLE = 3'd1,
    ST_SS   = 3'd2,
    ST_RUN  = 3'd3,
    ST_HIC  = 3'd4,
    ST_LOCK = 3'd5
  } pfs_state_e;

  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_DROP  = 3'd1;
  localparam logic [REG_AW-1:0] A_RESP  = 3'd2;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd3;
  localparam logic [REG_AW-1:0] A_PHFLT = 3'd4;

  localparam logic [1:0] RC_REPORT = 2'b00;
  localparam logic [1:0] RC_HIC    = 2'b01;
  localparam logic [1:0] RC_LOCK   = 2'b10;
endpackage

// File: rtl/pfs_regs.sv
module pfs_regs
  import pfs_pkg::*;
#(
  parameter int N_PH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [2:0]        set_stat,
  input  logic [N_PH-1:0]   set_ph,
  output logic              drop_en,
  output logic              ovr_en,
  output logic [N_PH-1:0]   drop_mask,
  output logic [5:0]        resp,
  output logic [2:0]        stat,
  output logic [N_PH-1:0]   phflt,
  output logic [REG_DW-1:0] rdata
);
  localparam int PAD = REG_DW - N_PH;

  logic [2:0]      stat_clr;
  logic [N_PH-1:0] ph_clr;

  always_comb begin
    stat_clr = '0;
    ph_clr   = '0;
    if (wr && addr == A_STAT)  stat_clr = wdata[2:0];
    if (wr && addr == A_PHFLT) ph_clr   = wdata[N_PH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_en   <= 1'b0;
      ovr_en    <= 1'b0;
      drop_mask <= '0;
      resp      <= '0;
      stat      <= '0;
      phflt     <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_CTRL: begin
            drop_en <= wdata[0];
            ovr_en  <= wdata[1];
          end
          A_DROP:  drop_mask <= wdata[N_PH-1:0];
          A_RESP:  resp      <= wdata[5:0];
          default: ;
        endcase
      end
      // a new fault wins over a clear arriving in the same cycle
      stat  <= (stat & ~stat_clr) | set_stat;
      phflt <= (phflt & ~ph_clr) | set_ph;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {6'b0, ovr_en, drop_en};
      A_DROP:  rdata = {{PAD{1'b0}}, drop_mask};
      A_RESP:  rdata = {2'b0, resp};
      A_STAT:  rdata = {5'b0, stat};
      A_PHFLT: rdata = {{PAD{1'b0}}, phflt};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pfs_limit.sv
module pfs_limit #(
  parameter int N_PH = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic [N_PH-1:0] noc_hit,
  output logic [N_PH-1:0] kill
);
  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         kill[g] <= 1'b0;
      else if (cyc_start) kill[g] <= noc_hit[g];
      else                kill[g] <= kill[g] | noc_hit[g];
    end
  end
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfs_pkg::*;
#(
  parameter int N_PH    = 6,
  parameter int SS_CYC  = 16,
  parameter int HIC_CYC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            pwm_en,
  input  logic            dflt_latch,
  input  logic            drop_en,
  input  logic            ovr_en,
  input  logic [N_PH-1:0] drop_mask,
  input  logic [5:0]      resp,
  input  logic            hit_oc2,
  input  logic            hit_noc,
  input  logic            hit_sh,
  output pfs_state_e      state,
  output logic [N_PH-1:0] act_mask
);
  localparam int CNT_MAX    = (SS_CYC > HIC_CYC) ? SS_CYC : HIC_CYC;
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam int PCW        = $clog2(N_PH + 1);
  localparam int DROP_LIMIT = N_PH / 2;

  logic          mode_q;
  logic [CW-1:0] cnt;
  logic [PCW-1:0] n_drop;
  logic          too_many;
  logic [N_PH-1:0] start_mask;
  logic [1:0]    c_oc2, c_noc, c_sh, c_dflt;
  logic          want_lock, want_hic;

  always_comb begin
    n_drop = '0;
    for (int i = 0; i < N_PH; i++) n_drop = n_drop + PCW'(drop_mask[i]);
  end

  assign too_many   = drop_en && (n_drop > PCW'(DROP_LIMIT));
  assign start_mask = drop_en ? ~drop_mask : '1;

  always_comb begin
    c_dflt = mode_q ? RC_LOCK : RC_HIC;
    c_oc2  = ovr_en ? resp[1:0] : c_dflt;
    c_noc  = ovr_en ? resp[3:2] : c_dflt;
    c_sh   = ovr_en ? resp[5:4] : c_dflt;
    want_lock = (hit_oc2 && c_oc2[1]) || (hit_noc && c_noc[1]) ||
                (hit_sh && c_sh[1]);
    want_hic  = (hit_oc2 && c_oc2 == RC_HIC) || (hit_noc && c_noc == RC_HIC) ||
                (hit_sh && c_sh == RC_HIC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      mode_q   <= 1'b0;
      cnt      <= '0;
      act_mask <= '0;
    end else if (!chip_en) begin
      state <= ST_INIT;
      cnt   <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          mode_q <= dflt_latch;
          state  <= ST_IDLE;
        end
        ST_IDLE: begin
          if (pwm_en) begin
            cnt <= '0;
            if (too_many) state <= ST_LOCK;
            else begin
              act_mask <= start_mask;
              state    <= ST_SS;
            end
          end
        end
        ST_SS, ST_RUN: begin
          if (!pwm_en)        state <= ST_IDLE;
          else if (want_lock) state <= ST_LOCK;
          else if (want_hic) begin
            state <= ST_HIC;
            cnt   <= '0;
          end else if (state == ST_SS) begin
            if (cnt == CW'(SS_CYC - 1)) state <= ST_RUN;
            else                        cnt   <= cnt + 1'b1;
          end
        end
        ST_HIC: begin
          if (cnt == CW'(HIC_CYC - 1)) state <= ST_IDLE;
          else                         cnt   <= cnt + 1'b1;
        end
        ST_LOCK: begin
          if (!pwm_en) state <= ST_IDLE;
        end
        default: state <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/phase_fault_supervisor.sv
module phase_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int N_PH    = 6,
  parameter int SS_CYC  = 16,
  parameter int HIC_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_i,
  input  logic              pwm_en_i,
  input  logic              dflt_latch_i,
  input  logic              cyc_start_i,
  input  logic [N_PH-1:0]   oc2_i,
  input  logic [N_PH-1:0]   noc_i,
  input  logic [N_PH-1:0]   short_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic [N_PH-1:0]   ph_en_o,
  output logic [N_PH-1:0]   sync_kill_o,
  output logic              fault_n_o,
  output logic [2:0]        state_o
);
  pfs_state_e      state;
  logic [N_PH-1:0] act_mask, live_mask;
  logic [N_PH-1:0] g_oc2, g_noc, g_sh;
  logic            hit_oc2, hit_noc, hit_sh;
  logic            drop_en, ovr_en;
  logic [N_PH-1:0] drop_mask, phflt;
  logic [5:0]      resp;
  logic [2:0]      stat;
  logic            live;

  assign live      = (state == ST_SS) || (state == ST_RUN);
  assign live_mask = live ? act_mask : '0;
  assign g_oc2     = oc2_i & live_mask;
  assign g_noc     = noc_i & live_mask;
  assign g_sh      = short_i & live_mask;
  assign hit_oc2   = |g_oc2;
  assign hit_noc   = |g_noc;
  assign hit_sh    = |g_sh;

  pfs_regs #(.N_PH(N_PH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .set_stat ({hit_sh, hit_noc, hit_oc2}),
    .set_ph   (g_oc2 | g_noc | g_sh),
    .drop_en  (drop_en),
    .ovr_en   (ovr_en),
    .drop_mask(drop_mask),
    .resp     (resp),
    .stat     (stat),
    .phflt    (phflt),
    .rdata    (reg_rdata_o)
  );

  pfs_seq #(.N_PH(N_PH), .SS_CYC(SS_CYC), .HIC_CYC(HIC_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en_i),
    .pwm_en    (pwm_en_i),
    .dflt_latch(dflt_latch_i),
    .drop_en   (drop_en),
    .ovr_en    (ovr_en),
    .drop_mask (drop_mask),
    .resp      (resp),
    .hit_oc2   (hit_oc2),
    .hit_noc   (hit_noc),
    .hit_sh    (hit_sh),
    .state     (state),
    .act_mask  (act_mask)
  );

  pfs_limit #(.N_PH(N_PH)) u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start_i),
    .noc_hit  (g_noc),
    .kill     (sync_kill_o)
  );

  assign ph_en_o   = live_mask;
  assign fault_n_o = ~((|stat) | (|phflt));
  assign state_o   = state;
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk #(
  parameter int N_PH = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chip_en_i,
  input logic            pwm_en_i,
  input logic [N_PH-1:0] noc_i,
  input logic [N_PH-1:0] ph_en_o,
  input logic [N_PH-1:0] sync_kill_o,
  input logic            fault_n_o,
  input logic [2:0]      state_o
);
  // R5
  kill_after_noc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(noc_i & ph_en_o)) |=> ((sync_kill_o & $past(noc_i & ph_en_o)) == $past(noc_i & ph_en_o)));

  // R6
  flag_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(noc_i & ph_en_o)) |=> !fault_n_o);

  // R2
  init_on_chip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |=> (state_o == 3'd0 && ph_en_o == '0));

  // R12
  stop_on_pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && chip_en_i && !pwm_en_i) |=> state_o == 3'd1);

  // R4
  run_phase_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |-> ($countones(ph_en_o) >= N_PH - N_PH / 2));

  // R9
  hiccup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 || state_o == 3'd5) |-> ph_en_o == '0);
endmodule

bind phase_fault_supervisor pfs_chk #(.N_PH(N_PH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_en_i  (chip_en_i),
  .pwm_en_i   (pwm_en_i),
  .noc_i      (noc_i),
  .ph_en_o    (ph_en_o),
  .sync_kill_o(sync_kill_o),
  .fault_n_o  (fault_n_o),
  .state_o    (state_o)
);

// File: tb/phase_fault_supervisor_tb.sv
`timescale 1ns/1ps
module phase_fault_supervisor_tb;
  localparam int N = 6;
  localparam int SS = 16;
  localparam int HC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, pwm_en = 1'b0, dflt_latch = 1'b0, cyc_start = 1'b0;
  logic [N-1:0] oc2 = '0, noc = '0, sh = '0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [N-1:0] ph_en, kill;
  logic fault_n;
  logic [2:0] state;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  phase_fault_supervisor #(.N_PH(N), .SS_CYC(SS), .HIC_CYC(HC)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en), .pwm_en_i(pwm_en),
    .dflt_latch_i(dflt_latch), .cyc_start_i(cyc_start), .oc2_i(oc2),
    .noc_i(noc), .short_i(sh), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ph_en_o(ph_en),
    .sync_kill_o(kill), .fault_n_o(fault_n), .state_o(state)
  );

  // {drop_en, mask[5:0], state[2:0], ph_en[5:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 6'b111111, 3'd2, 6'b111111},
    {1'b1, 6'b000000, 3'd2, 6'b111111},
    {1'b1, 6'b000101, 3'd2, 6'b111010},
    {1'b1, 6'b000111, 3'd2, 6'b111000},
    {1'b1, 6'b001111, 3'd5, 6'b000000},
    {1'b1, 6'b111111, 3'd5, 6'b000000},
    {1'b1, 6'b100011, 3'd2, 6'b011100}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, 16'(reg_rdata), 16'(exp));
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 state", 16'(state), 16'd0);
    chk("R1 ph_en", 16'(ph_en), 16'd0);
    chk("R1 kill", 16'(kill), 16'd0);
    chk("R1 fault_n", 16'(fault_n), 16'd1);
    rd("R1 stat", 3'd3, 8'h00);
    rd("R1 ctrl", 3'd0, 8'h00);

    // R2 init -> idle
    chip_en = 1'b1;
    step();
    chk("R2 idle", 16'(state), 16'd1);

    // R3 R4 R12 vector walk
    for (int i = 0; i < 7; i++) begin
      wr(3'd0, {7'b0, VEC[i][15]});
      wr(3'd1, {2'b0, VEC[i][14:9]});
      pwm_en = 1'b1;
      step();
      chk("R3/R4 start state", 16'(state), 16'(VEC[i][8:6]));
      chk("R3/R4 start ph_en", 16'(ph_en), 16'(VEC[i][5:0]));
      pwm_en = 1'b0;
      step();
      chk("R12/R10 stop", 16'(state), 16'd1);
    end

    // R3 soft-start length; override on with all codes report-only
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h00);
    pwm_en = 1'b1;
    step();
    chk("R3 ss entry", 16'(state), 16'd2);
    repeat (SS - 1) step();
    chk("R3 ss hold", 16'(state), 16'd2);
    step();
    chk("R3 run", 16'(state), 16'd3);

    // R5 cycle-by-cycle kill
    noc = 6'b000100;
    step();
    noc = '0;
    chk("R5 kill set", 16'(kill), 16'h04);
    chk("R8 report only", 16'(state), 16'd3);
    chk("R6 flag low", 16'(fault_n), 16'd0);
    repeat (3) step();
    chk("R5 kill held", 16'(kill), 16'h04);
    cyc_start = 1'b1;
    step();
    cyc_start = 1'b0;
    chk("R5 kill cleared", 16'(kill), 16'h00);
    noc = 6'b000010; cyc_start = 1'b1;
    step();
    noc = '0; cyc_start = 1'b0;
    chk("R5 kill new cycle", 16'(kill), 16'h02);
    step();
    chk("R5 kill repeat held", 16'(kill), 16'h02);
    cyc_start = 1'b1;
    step();
    cyc_start = 1'b0;
    chk("R5 kill end", 16'(kill), 16'h00);

    // R6 sticky status, W1C
    rd("R6 stat", 3'd3, 8'h02);
    rd("R6 phflt", 3'd4, 8'h06);
    wr(3'd3, 8'h02);
    rd("R6 stat cleared", 3'd3, 8'h00);
    chk("R6 flag still low", 16'(fault_n), 16'd0);
    wr(3'd4, 8'h3F);
    chk("R6 flag released", 16'(fault_n), 16'd1);

    // R12 run -> idle
    pwm_en = 1'b0;
    step();
    chk("R12 run stop", 16'(state), 16'd1);

    // R11 fault outside run
    oc2 = 6'b000001;
    step();
    oc2 = '0;
    rd("R11 idle ignored", 3'd3, 8'h00);
    chk("R11 idle flag", 16'(fault_n), 16'd1);

    // R11 removed phase ignored, R8 hiccup code
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h15);
    pwm_en = 1'b1;
    step();
    chk("R3 ss masked", 16'(ph_en), 16'h3E);
    oc2 = 6'b000001;
    step();
    oc2 = '0;
    chk("R11 removed state", 16'(state), 16'd2);
    chk("R11 removed flag", 16'(fault_n), 16'd1);
    oc2 = 6'b000010;
    step();
    oc2 = '0;
    chk("R8 hiccup", 16'(state), 16'd4);
    chk("R9 hiccup off", 16'(ph_en), 16'd0);
    rd("R6 oc2 stat", 3'd3, 8'h01);
    rd("R6 oc2 phase", 3'd4, 8'h02);

    // R9 hiccup timing
    repeat (HC - 1) step();
    chk("R9 hiccup hold", 16'(state), 16'd4);
    step();
    chk("R9 hiccup idle", 16'(state), 16'd1);
    step();
    chk("R9 restart", 16'(state), 16'd2);

    // R8 latch code on short, most severe wins
    wr(3'd2, 8'h25);
    sh = 6'b000100; noc = 6'b000100;
    step();
    sh = '0; noc = '0;
    chk("R8 latch", 16'(state), 16'd5);
    chk("R10 lock off", 16'(ph_en), 16'd0);

    // R10 leaving latch-off
    repeat (2) step();
    chk("R10 lock hold", 16'(state), 16'd5);
    pwm_en = 1'b0;
    step();
    chk("R10 pwm release", 16'(state), 16'd1);
    pwm_en = 1'b1;
    step();
    chk("R10 soft restart", 16'(state), 16'd2);
    sh = 6'b000100;
    step();
    sh = '0;
    chk("R10 lock again", 16'(state), 16'd5);
    chip_en = 1'b0;
    step();
    chk("R10 chip release", 16'(state), 16'd0);

    // R7 default responses from latched mode
    wr(3'd3, 8'h07);
    wr(3'd4, 8'h3F);
    wr(3'd0, 8'h00);
    pwm_en = 1'b0;
    dflt_latch = 1'b1;
    chip_en = 1'b1;
    step();
    chk("R2 relatch idle", 16'(state), 16'd1);
    dflt_latch = 1'b0;
    pwm_en = 1'b1;
    step();
    chk("R7 ss", 16'(state), 16'd2);
    oc2 = 6'b000001;
    step();
    oc2 = '0;
    chk("R7 default latch", 16'(state), 16'd5);
    chip_en = 1'b0;
    step();
    chip_en = 1'b1;
    step();
    chk("R2 init again", 16'(state), 16'd1);
    step();
    chk("R7 ss again", 16'(state), 16'd2);
    noc = 6'b000001;
    step();
    noc = '0;
    chk("R7 default hiccup", 16'(state), 16'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule